// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command front end of a 16-bit parallel NOR-style flash with 256K words. The write port is sampled on a one-clock strobe. The block follows the multi-cycle unlock sequences that move the part between three modes: normal array reads, identification reads and CFI query reads. The current mode is shown on a two-bit output. The read path is a registered multiplexer with four sources: array data passed through from an input port, the two identification words, a small computed CFI parameter table, and a fixed status word that is returned while an internal program or erase is in progress.

Only the low byte of each write is decoded. A write that does not fit the next expected step of a sequence returns the block to array reads. The exit command is refused while the busy input is high. A device reset input, sampled on the clock, forces array reads and drops any sequence that is partly entered. The system reset is asynchronous and is released through a two-flop synchroniser.

Top module: `flash_cmd_front`

## Requirements
- R1: While the system reset is low, and after it is released, `mode` reads 0 (array reads) and no sequence is pending.
- R2: Three writes with low bytes AAh at word address 555h, then 55h at 2AAh, then 90h at 555h set `mode` to 1 (identification) at the clock edge of the third write.
- R3: The same first two writes followed by 98h at 555h set `mode` to 2 (CFI query).
- R4: With no sequence pending, one write of 89h to word address 055h sets `mode` to 2.
- R5: A write that does not match the next expected step aborts the sequence and sets `mode` to 0. This includes an unrecognised write when no sequence is pending. The next write is then decoded as the first step.
- R6: Data bits 15..8 of a write never affect decoding.
- R7: In mode 1 with busy low, reading word address 0 returns 00BFh, reading address 1 returns 2321h (2322h when ALT_DEVICE=1), and reading any other address returns 0000h.
- R8: In mode 2 with busy low, reading address a < 64 returns 0051h, 0052h, 0059h and 0001h for a = 10h, 11h, 12h and 13h, returns ADDR_W+1 (0013h) for a = 27h, and returns 0000h for every other a. Any a >= 64 returns 0000h.
- R9: A write with low byte F0h to any address, with busy low, sets `mode` to 0 and clears any pending sequence.
- R10: While busy is high, a write with low byte F0h is ignored. Both the mode and any partly entered sequence are kept.
- R11: While busy is high, the read returns the status word 0080h in every mode.
- R12: In mode 0 with busy low, the read returns `array_rdata`. Every read result appears on `rd_data` one clock after `rd_addr`, `busy` and `mode` are presented.
- R13: A device reset (`dev_rst_n` low at a clock edge) sets `mode` to 0 and clears any pending sequence in every mode. It takes priority over a write in the same cycle.
- R14: `mode` takes only the values 0, 1 and 2, and it changes only at an edge where a write is strobed or the device reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dev_rst_n | input | 1 | Active-low device reset, sampled on the clock |
| wr_stb | input | 1 | One-cycle write cycle strobe |
| wr_addr | input | 18 | Word address of the write cycle |
| wr_data | input | 16 | Data of the write cycle (low byte decoded) |
| busy | input | 1 | Internal program or erase in progress |
| rd_addr | input | 18 | Word address of the read |
| array_rdata | input | 16 | Data from the storage array |
| rd_data | output | 16 | Registered read data |
| mode | output | 2 | Current mode: 0 array, 1 identification, 2 CFI |

## Verification
The hardest case to reach is a sequence that is half entered when a refused exit command arrives. In that case the F0h write must neither abort the pending unlock nor change the mode, and this cannot be seen until the sequence is completed. The bench writes the first unlock step, raises busy, writes F0h, drops busy and finishes the identification entry, and then expects mode 1. A similar check confirms that a device reset clears a pending step: the remaining steps are replayed after the reset, and they must then be treated as stray writes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_ID   = 2'd1,
    MODE_CFI  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT1 = 2'd1,
    SEQ_GOT2 = 2'd2
  } seq_e;

  // Per-write match flags produced by the decoder
  typedef struct packed {
    logic exit_cmd;
    logic unlock1;
    logic unlock2;
    logic id_go;
    logic cfi_go;
    logic cfi_short;
  } wr_hit_t;

  localparam logic [7:0]  CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0]  CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0]  CMD_ID_ENTER = 8'h90;
  localparam logic [7:0]  CMD_CFI_ENTER = 8'h98;
  localparam logic [7:0]  CMD_CFI_SHORT = 8'h89;
  localparam logic [7:0]  CMD_EXIT     = 8'hF0;

  localparam logic [11:0] ADR_UNLOCK_A = 12'h555;
  localparam logic [11:0] ADR_UNLOCK_B = 12'h2AA;
  localparam logic [11:0] ADR_SHORT    = 12'h055;

  localparam logic [15:0] MFR_WORD     = 16'h00BF;
  localparam logic [15:0] DEV_WORD_A   = 16'h2321;
  localparam logic [15:0] DEV_WORD_B   = 16'h2322;

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wr_hit_t           hit
);

  localparam logic [ADDR_W-1:0] A_UNLK_A = ADDR_W'(ADR_UNLOCK_A);
  localparam logic [ADDR_W-1:0] A_UNLK_B = ADDR_W'(ADR_UNLOCK_B);
  localparam logic [ADDR_W-1:0] A_SHORT  = ADDR_W'(ADR_SHORT);

  logic [7:0] cmd_byte;
  logic       at_unlk_a;
  logic       at_unlk_b;
  logic       at_short;
  logic       unused_hi_byte;

  // Only the low byte carries a command
  assign cmd_byte       = wr_data[7:0];
  assign unused_hi_byte = ^wr_data[DATA_W-1:8];

  assign at_unlk_a = (wr_addr == A_UNLK_A);
  assign at_unlk_b = (wr_addr == A_UNLK_B);
  assign at_short  = (wr_addr == A_SHORT);

  always_comb begin
    hit           = '0;
    hit.exit_cmd  = (cmd_byte == CMD_EXIT);
    hit.unlock1   = at_unlk_a && (cmd_byte == CMD_UNLOCK_A);
    hit.unlock2   = at_unlk_b && (cmd_byte == CMD_UNLOCK_B);
    hit.id_go     = at_unlk_a && (cmd_byte == CMD_ID_ENTER);
    hit.cfi_go    = at_unlk_a && (cmd_byte == CMD_CFI_ENTER);
    hit.cfi_short = at_short  && (cmd_byte == CMD_CFI_SHORT);
  end

endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
  import flash_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    dev_rst_n,
  input  logic    wr_stb,
  input  logic    busy,
  input  wr_hit_t hit,
  output mode_e   mode_q
);

  seq_e  seq_q;
  seq_e  seq_d;
  mode_e mode_d;
  logic  state_en;

  // State can only move on a write or a device reset
  assign state_en = wr_stb || !dev_rst_n;

  always_comb begin
    seq_d  = seq_q;
    mode_d = mode_q;
    if (!dev_rst_n) begin
      seq_d  = SEQ_IDLE;
      mode_d = MODE_READ;
    end else if (wr_stb) begin
      if (hit.exit_cmd) begin
        if (!busy) begin
          seq_d  = SEQ_IDLE;
          mode_d = MODE_READ;
        end
      end else begin
        case (seq_q)
          SEQ_IDLE: begin
            if (hit.unlock1) begin
              seq_d = SEQ_GOT1;
            end else if (hit.cfi_short) begin
              mode_d = MODE_CFI;
            end else begin
              mode_d = MODE_READ;
            end
          end
          SEQ_GOT1: begin
            if (hit.unlock2) begin
              seq_d = SEQ_GOT2;
            end else begin
              seq_d  = SEQ_IDLE;
              mode_d = MODE_READ;
            end
          end
          SEQ_GOT2: begin
            seq_d = SEQ_IDLE;
            if (hit.id_go) begin
              mode_d = MODE_ID;
            end else if (hit.cfi_go) begin
              mode_d = MODE_CFI;
            end else begin
              mode_d = MODE_READ;
            end
          end
          default: begin
            seq_d  = SEQ_IDLE;
            mode_d = MODE_READ;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SEQ_IDLE;
      mode_q <= MODE_READ;
    end else if (state_en) begin
      seq_q  <= seq_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/flash_cfi_rom.sv
module flash_cfi_rom #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CFI_AW = 6
) (
  input  logic [CFI_AW-1:0] idx,
  output logic [DATA_W-1:0] word
);

  localparam logic [DATA_W-1:0] SIZE_LOG2 = DATA_W'(ADDR_W + 1);

  logic [7:0] idx8;

  assign idx8 = 8'(idx);

  always_comb begin
    case (idx8)
      8'h10:   word = DATA_W'(16'h0051);
      8'h11:   word = DATA_W'(16'h0052);
      8'h12:   word = DATA_W'(16'h0059);
      8'h13:   word = DATA_W'(16'h0001);
      8'h27:   word = SIZE_LOG2;
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int unsigned     ADDR_W      = 18,
  parameter int unsigned     DATA_W      = 16,
  parameter int unsigned     CFI_AW      = 6,
  parameter bit              ALT_DEVICE  = 1'b0,
  parameter logic [15:0]     STATUS_WORD = 16'h0080
) (
  input  logic              clk,
  input  mode_e             mode,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] ID_ADR_MFR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ID_ADR_DEV = ADDR_W'(1);

  logic [DATA_W-1:0] dev_word;
  logic [DATA_W-1:0] rom_word;
  logic [DATA_W-1:0] sel_word;
  logic              cfi_in_range;

  generate
    if (ALT_DEVICE) begin : g_dev_b
      assign dev_word = DATA_W'(DEV_WORD_B);
    end else begin : g_dev_a
      assign dev_word = DATA_W'(DEV_WORD_A);
    end
  endgenerate

  flash_cfi_rom #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CFI_AW (CFI_AW)
  ) u_cfi_rom (
    .idx  (rd_addr[CFI_AW-1:0]),
    .word (rom_word)
  );

  assign cfi_in_range = (rd_addr[ADDR_W-1:CFI_AW] == '0);

  always_comb begin
    if (busy) begin
      sel_word = DATA_W'(STATUS_WORD);
    end else begin
      case (mode)
        MODE_ID: begin
          if (rd_addr == ID_ADR_MFR) begin
            sel_word = DATA_W'(MFR_WORD);
          end else if (rd_addr == ID_ADR_DEV) begin
            sel_word = dev_word;
          end else begin
            sel_word = '0;
          end
        end
        MODE_CFI: sel_word = cfi_in_range ? rom_word : '0;
        default:  sel_word = array_rdata;
      endcase
    end
  end

  // Datapath register, loaded every cycle, no reset needed
  always_ff @(posedge clk) begin
    rd_data <= sel_word;
  end

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CFI_AW      = 6,
  parameter bit          ALT_DEVICE  = 1'b0,
  parameter logic [15:0] STATUS_WORD = 16'h0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        mode
);

  logic    rst_core_n;
  wr_hit_t hit;
  mode_e   mode_q;

  flash_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  flash_cmd_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_decode (
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hit     (hit)
  );

  flash_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .dev_rst_n (dev_rst_n),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .hit       (hit),
    .mode_q    (mode_q)
  );

  flash_read_mux #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CFI_AW      (CFI_AW),
    .ALT_DEVICE  (ALT_DEVICE),
    .STATUS_WORD (STATUS_WORD)
  ) u_read_mux (
    .clk         (clk),
    .mode        (mode_q),
    .busy        (busy),
    .rd_addr     (rd_addr),
    .array_rdata (array_rdata),
    .rd_data     (rd_data)
  );

  assign mode = mode_q;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CFI_AW      = 6,
  parameter logic [15:0] STATUS_WORD = 16'h0080
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_rst_n,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] array_rdata,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        mode
);

  logic exit_wr;
  logic out_of_rom;

  assign exit_wr    = wr_stb && dev_rst_n && (wr_data[7:0] == 8'hF0);
  assign out_of_rom = (rd_addr[ADDR_W-1:CFI_AW] != '0);

  AST_DEVRST_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |=> (mode == 2'd0)); // R13

  AST_EXIT_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_wr && !busy) |=> (mode == 2'd0)); // R9

  AST_EXIT_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_wr && busy) |=> $stable(mode)); // R10

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3); // R14

  AST_MODE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(wr_stb || !dev_rst_n)); // R14

  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (rd_data == DATA_W'(STATUS_WORD))); // R11

  AST_ID_MFR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == 2'd1 && !busy && rd_addr == '0) |-> (rd_data == DATA_W'(16'h00BF))); // R7

  AST_CFI_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == 2'd2 && !busy && out_of_rom) |-> (rd_data == '0)); // R8

  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode == 2'd0 && !busy) |-> (rd_data == $past(array_rdata))); // R12

endmodule

bind flash_cmd_front flash_cmd_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .CFI_AW      (CFI_AW),
  .STATUS_WORD (STATUS_WORD)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dev_rst_n   (dev_rst_n),
  .wr_stb      (wr_stb),
  .wr_data     (wr_data),
  .busy        (busy),
  .rd_addr     (rd_addr),
  .array_rdata (array_rdata),
  .rd_data     (rd_data),
  .mode        (mode)
);

// File: tb/test_flash_cmd_front.sv
module test_flash_cmd_front;

  logic        clk;
  logic        rst_n;
  logic        dev_rst_n;
  logic        wr_stb;
  logic [17:0] wr_addr;
  logic [15:0] wr_data;
  logic        busy;
  logic [17:0] rd_addr;
  logic [15:0] array_rdata;
  logic [15:0] rd_data;
  logic [1:0]  mode;

  int total;
  int bad;
  bit done;

  flash_cmd_front i_flash_cmd_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_rst_n   (dev_rst_n),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .busy        (busy),
    .rd_addr     (rd_addr),
    .array_rdata (array_rdata),
    .rd_data     (rd_data),
    .mode        (mode)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic rd(input logic [17:0] a, input logic [15:0] arr);
    rd_addr     = a;
    array_rdata = arr;
    @(negedge clk);
  endtask

  task automatic enter(input logic [7:0] third);
    wr(18'h555, 16'h00AA);
    wr(18'h2AA, 16'h0055);
    wr(18'h555, {8'h00, third});
  endtask

  function automatic logic [15:0] exp_cfi(input logic [17:0] a);
    if (a >= 18'd64) return 16'h0000;
    case (a)
      18'h10:  return 16'h0051;
      18'h11:  return 16'h0052;
      18'h12:  return 16'h0059;
      18'h13:  return 16'h0001;
      18'h27:  return 16'd19;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] exp_id(input logic [17:0] a);
    if (a == 18'd0) return 16'h00BF;
    if (a == 18'd1) return 16'h2321;
    return 16'h0000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk("watchdog", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; dev_rst_n = 1'b1; wr_stb = 1'b0;
    wr_addr = '0; wr_data = '0; busy = 1'b0;
    rd_addr = '0; array_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", {30'd0, mode}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mode after reset", {30'd0, mode}, 32'd0);

    // R12: array pass-through sweep
    for (int a = 0; a < 40; a++) begin
      rd(18'(a), 16'(a * 37 + 5));
      chk("R12 array read", {16'd0, rd_data}, {16'd0, 16'(a * 37 + 5)});
    end
    rd(18'h3FFFF, 16'hBEEF);
    chk("R12 array top address", {16'd0, rd_data}, 32'h0000BEEF);

    // R2 / R7: identification entry and sweep
    enter(8'h90);
    chk("R2 id entry", {30'd0, mode}, 32'd1);
    for (int a = 0; a < 16; a++) begin
      rd(18'(a), 16'h5A5A);
      chk("R7 id read", {16'd0, rd_data}, {16'd0, exp_id(18'(a))});
    end
    rd(18'h3FFFF, 16'h5A5A);
    chk("R7 id high address", {16'd0, rd_data}, 32'd0);

    // R9: exit from any address
    wr(18'h12345, 16'h00F0);
    chk("R9 exit from id", {30'd0, mode}, 32'd0);

    // R3 / R8: three-cycle CFI entry and sweep
    enter(8'h98);
    chk("R3 cfi entry", {30'd0, mode}, 32'd2);
    for (int a = 0; a < 128; a++) begin
      rd(18'(a), 16'h1111);
      chk("R8 cfi read", {16'd0, rd_data}, {16'd0, exp_cfi(18'(a))});
    end
    rd(18'h20010, 16'h1111);
    chk("R8 cfi alias outside table", {16'd0, rd_data}, 32'd0);
    wr(18'h00000, 16'h00F0);
    chk("R9 exit from cfi", {30'd0, mode}, 32'd0);

    // R4: single-cycle CFI entry
    wr(18'h055, 16'h0089);
    chk("R4 short cfi entry", {30'd0, mode}, 32'd2);
    wr(18'h3FFFF, 16'h00F0);
    chk("R9 exit after short entry", {30'd0, mode}, 32'd0);

    // R6: upper byte is ignored
    wr(18'h555, 16'hFFAA);
    wr(18'h2AA, 16'hA555);
    wr(18'h555, 16'h1290);
    chk("R6 id entry with upper byte set", {30'd0, mode}, 32'd1);
    wr(18'h0, 16'h77F0);
    chk("R6 exit with upper byte set", {30'd0, mode}, 32'd0);
    wr(18'h055, 16'h7789);
    chk("R6 short entry with upper byte set", {30'd0, mode}, 32'd2);
    wr(18'h0, 16'h00F0);

    // R5: aborts at step two
    for (int k = 0; k < 4; k++) begin
      logic [17:0] ba;
      logic [15:0] bd;
      ba = (k == 0) ? 18'h2AA : (k == 1) ? 18'h555 : (k == 2) ? 18'h2AB : 18'h02AA;
      bd = (k == 0) ? 16'h00AA : (k == 1) ? 16'h0055 : (k == 2) ? 16'h0055 : 16'h0090;
      enter(8'h90);
      wr(18'h555, 16'h00AA);
      chk("R5 id kept while step pending", {30'd0, mode}, 32'd1);
      wr(ba, bd);
      chk("R5 abort at step two", {30'd0, mode}, 32'd0);
    end
    // R5: abort at step three, then sequence really cleared
    enter(8'h98);
    wr(18'h555, 16'h00AA);
    wr(18'h2AA, 16'h0055);
    wr(18'h555, 16'h0080);
    chk("R5 abort at step three", {30'd0, mode}, 32'd0);
    wr(18'h555, 16'h0090);
    chk("R5 no stale step after abort", {30'd0, mode}, 32'd0);
    wr(18'h055, 16'h0089);
    wr(18'h00000, 16'h1234);
    chk("R5 stray write leaves cfi", {30'd0, mode}, 32'd0);

    // R11 / R10: busy behaviour
    enter(8'h90);
    busy = 1'b1;
    rd(18'h0, 16'h4444);
    chk("R11 status in id mode", {16'd0, rd_data}, 32'h00000080);
    wr(18'h0, 16'h00F0);
    chk("R10 exit refused while busy", {30'd0, mode}, 32'd1);
    busy = 1'b0;
    rd(18'h0, 16'h4444);
    chk("R7 mfr after busy", {16'd0, rd_data}, 32'h000000BF);
    wr(18'h0, 16'h00F0);
    busy = 1'b1;
    rd(18'h7, 16'h4444);
    chk("R11 status in read mode", {16'd0, rd_data}, 32'h00000080);
    busy = 1'b0;
    // R10: pending step survives a refused exit
    wr(18'h555, 16'h00AA);
    busy = 1'b1;
    wr(18'h3, 16'h00F0);
    busy = 1'b0;
    wr(18'h2AA, 16'h0055);
    wr(18'h555, 16'h0090);
    chk("R10 sequence kept across refused exit", {30'd0, mode}, 32'd1);
    wr(18'h0, 16'h00F0);

    // R13: device reset in every mode, beating a same-cycle write
    for (int m = 0; m < 3; m++) begin
      if (m == 1) enter(8'h90);
      if (m == 2) enter(8'h98);
      @(negedge clk);
      dev_rst_n = 1'b0;
      wr_addr = 18'h055; wr_data = 16'h0089; wr_stb = 1'b1;
      @(negedge clk);
      dev_rst_n = 1'b1; wr_stb = 1'b0;
      chk("R13 device reset", {30'd0, mode}, 32'd0);
    end
    // R13: pending step cleared by device reset
    wr(18'h555, 16'h00AA);
    @(negedge clk); dev_rst_n = 1'b0;
    @(negedge clk); dev_rst_n = 1'b1;
    wr(18'h2AA, 16'h0055);
    wr(18'h555, 16'h0090);
    chk("R13 pending step cleared", {30'd0, mode}, 32'd0);

    // R14: mode holds without writes
    enter(8'h98);
    repeat (20) @(negedge clk);
    chk("R14 mode holds", {30'd0, mode}, 32'd2);

    // R1: system reset from CFI mode
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", {30'd0, mode}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mode after second reset", {30'd0, mode}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule